// File: doc/BRIEF.md
# Sensor Acquisition and Sleep Sequencer

This block is the power and measurement controller of a host-polled sensing device. It watches two inputs from the host: an active-low select line and a serial clock. From their timing alone it decides when to start a measurement burst, when to sleep and when to wake. Every duration is counted in ticks of a fixed reference clock and set by a parameter. Both host inputs pass through a synchronizer of parameterised depth, and all edges are detected in the reference-clock domain.

The measurement engine sits outside the block. The block asks for a burst with a one-cycle `burst_start` pulse and learns that the burst has finished from `burst_done`. The `data_rdy` output tells the host when it may shift data. It is low during calibration, during a burst and during sleep, and it rises when fresh results are available. The `asleep` output reports the sleep state.

Each rising edge of the select line requests one burst, after a delay. That delay is a short settle time if serial clocks arrived while the line was low. It is a longer hold time if the low pulse carried no clocks, which is the dummy trigger case. If the select line is held high, bursts run freely at a fixed period. If the line is held low and quiet, the block sleeps and wakes periodically for one drift-compensation burst each time.

Top module: `acq_sleep_seq`

## Requirements
- R1: After reset, `data_rdy`, `burst_start` and `asleep` are low. `data_rdy` stays low for CAL_TICKS cycles of calibration and then rises.
- R2: When the select line rises at the end of a low phase that contained at least one serial clock rising edge, `burst_start` pulses about SETTLE_TICKS cycles later. `data_rdy` stays high during that delay.
- R3: When the select line rises at the end of a low phase with no serial clock edges, exactly one burst follows, about DUMMY_HOLD_TICKS cycles later. This holds whether the block was awake or asleep when the line rose.
- R4: `burst_start` is high for exactly one cycle. `data_rdy` is low from that cycle until `burst_done` is seen, and it is high in the cycle after `burst_done`.
- R5: While the select line is low and idle, `asleep` rises about QUIET_TICKS cycles after the last activity. `data_rdy` is low whenever `asleep` is high.
- R6: While asleep with the select line held low, the block starts a burst about WAKE_TICKS + SETTLE_TICKS cycles after sleep entry. Once that burst is done it returns to sleep after the quiet time.
- R7: A serial clock rising edge during sleep wakes the block: `asleep` falls and `data_rdy` rises. It does not start a burst.
- R8: With the select line held high, the block starts a burst FREE_RUN_TICKS cycles after calibration ends and FREE_RUN_TICKS cycles after each burst completes.
- R9: Select-line edges and serial clocks that arrive while a burst is pending or running neither shift the pending burst nor add another burst.
- R10: Each serial clock rising edge while the select line is low restarts the quiet time.
- R11: If a select-line rising edge arrives in the same cycle as the quiet-time expiry, exactly one burst results, with the delay given by R2 or R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that counts all intervals |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low select line from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| burst_done | input | 1 | Pulse from the measurement engine when a burst ends |
| data_rdy | output | 1 | High when the host may shift data and results are fresh |
| burst_start | output | 1 | One-cycle request to begin a measurement burst |
| asleep | output | 1 | High while the block is in sleep |

## Verification
Two functions can fall in the same cycle: the select-line rising edge that requests a burst, and the quiet-time expiry that puts the block to sleep. The stimulus holds the select line low without activity for the quiet time plus a random offset of a few cycles either side, so the synchronized edge lands before, on or after the expiry cycle. Some frames carry a random number of serial clocks. Each case is judged by counting bursts, which must be exactly one, and by comparing the request latency with the settle or dummy-hold delay that a bench function predicts from the frame content.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

   typedef enum logic [2:0] {
      ST_CAL,
      ST_READY,
      ST_PEND,
      ST_BURST,
      ST_SLEEP
   } acq_state_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise,
   output logic fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("acq_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
         prev_q  <= RESET_VAL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;

endmodule

// File: rtl/acq_interval_timer.sv
module acq_interval_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   assign expired = run && (cnt_q == (limit - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (run && !expired)
         cnt_q <= cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/acq_frame_tracker.sv
module acq_frame_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_low,
   input  logic sel_fall,
   input  logic sclk_rise,
   output logic clocked
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         clocked <= 1'b0;
      else if (sel_fall)
         clocked <= 1'b0;
      else if (sclk_rise && sel_low)
         clocked <= 1'b1;
   end

endmodule

// File: rtl/acq_sleep_seq.sv
module acq_sleep_seq
   import acq_seq_pkg::*;
#(
   parameter int SYNC_STAGES      = 2,
   parameter int CAL_TICKS        = 525000,
   parameter int QUIET_TICKS      = 35,
   parameter int SETTLE_TICKS     = 1000,
   parameter int DUMMY_HOLD_TICKS = 700,
   parameter int WAKE_TICKS       = 3000000,
   parameter int FREE_RUN_TICKS   = 58824
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n,
   input  logic sclk,
   input  logic burst_done,
   output logic data_rdy,
   output logic burst_start,
   output logic asleep
);

   localparam int MAX_TICKS = max_of(max_of(max_of(CAL_TICKS, QUIET_TICKS),
                                            max_of(SETTLE_TICKS, DUMMY_HOLD_TICKS)),
                                     max_of(WAKE_TICKS, FREE_RUN_TICKS));
   localparam int CNT_W = $clog2(MAX_TICKS + 1);

   localparam logic [CNT_W-1:0] L_CAL    = CNT_W'(CAL_TICKS);
   localparam logic [CNT_W-1:0] L_QUIET  = CNT_W'(QUIET_TICKS);
   localparam logic [CNT_W-1:0] L_SETTLE = CNT_W'(SETTLE_TICKS);
   localparam logic [CNT_W-1:0] L_DUMMY  = CNT_W'(DUMMY_HOLD_TICKS);
   localparam logic [CNT_W-1:0] L_WAKE   = CNT_W'(WAKE_TICKS);
   localparam logic [CNT_W-1:0] L_FREE   = CNT_W'(FREE_RUN_TICKS);

   generate
      if (CAL_TICKS < 2 || QUIET_TICKS < 2 || SETTLE_TICKS < 2 ||
          DUMMY_HOLD_TICKS < 2 || WAKE_TICKS < 2 || FREE_RUN_TICKS < 2) begin : g_bad_ticks
         $error("acq_sleep_seq: every interval must be at least 2 ticks");
      end
      if (QUIET_TICKS >= WAKE_TICKS) begin : g_bad_wake
         $error("acq_sleep_seq: QUIET_TICKS must be below WAKE_TICKS");
      end
   endgenerate

   // synchronized host inputs
   logic sel_hi, sel_rise, sel_fall;
   logic sclk_lvl, sclk_rise, sclk_fall;

   acq_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sel_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sel_n),
      .level    (sel_hi),
      .rise     (sel_rise),
      .fall     (sel_fall)
   );

   acq_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sclk_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sclk),
      .level    (sclk_lvl),
      .rise     (sclk_rise),
      .fall     (sclk_fall)
   );

   logic frame_clocked;

   acq_frame_tracker u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_low   (~sel_hi),
      .sel_fall  (sel_fall),
      .sclk_rise (sclk_rise),
      .clocked   (frame_clocked)
   );

   // sequencer state
   acq_state_e       cur_q, nxt;
   logic [CNT_W-1:0] pend_len_q, pend_len_d;
   logic [CNT_W-1:0] limit;
   logic             tmr_run, tmr_clear, expired;
   logic             ready_q, start_q, sleep_q;
   logic [CNT_W-1:0] edge_delay;

   assign edge_delay = frame_clocked ? L_SETTLE : L_DUMMY;

   always_comb begin
      nxt        = cur_q;
      pend_len_d = pend_len_q;
      unique case (cur_q)
         ST_CAL: begin
            if (expired) nxt = ST_READY;
         end
         ST_READY: begin
            if (sel_rise) begin
               nxt        = ST_PEND;
               pend_len_d = edge_delay;
            end else if (expired) begin
               nxt = sel_hi ? ST_BURST : ST_SLEEP;
            end
         end
         ST_PEND: begin
            if (expired) nxt = ST_BURST;
         end
         ST_BURST: begin
            if (burst_done) nxt = ST_READY;
         end
         ST_SLEEP: begin
            if (sel_rise) begin
               nxt        = ST_PEND;
               pend_len_d = edge_delay;
            end else if (sclk_rise) begin
               nxt = ST_READY;
            end else if (expired) begin
               nxt        = ST_PEND;
               pend_len_d = L_SETTLE;
            end
         end
         default: nxt = ST_CAL;
      endcase
   end

   always_comb begin
      limit   = L_CAL;
      tmr_run = 1'b1;
      unique case (cur_q)
         ST_CAL:   limit = L_CAL;
         ST_READY: limit = sel_hi ? L_FREE : L_QUIET;
         ST_PEND:  limit = pend_len_q;
         ST_SLEEP: limit = L_WAKE;
         default:  tmr_run = 1'b0;
      endcase
   end

   assign tmr_clear = (nxt != cur_q) ||
                      ((cur_q == ST_READY) && (sel_rise || sel_fall || sclk_rise));

   acq_interval_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (tmr_clear),
      .run     (tmr_run),
      .limit   (limit),
      .expired (expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q      <= ST_CAL;
         pend_len_q <= L_SETTLE;
         ready_q    <= 1'b0;
         start_q    <= 1'b0;
         sleep_q    <= 1'b0;
      end else begin
         cur_q      <= nxt;
         pend_len_q <= pend_len_d;
         ready_q    <= (nxt == ST_READY) || (nxt == ST_PEND);
         start_q    <= (nxt == ST_BURST) && (cur_q != ST_BURST);
         sleep_q    <= (nxt == ST_SLEEP);
      end
   end

   assign data_rdy    = ready_q;
   assign burst_start = start_q;
   assign asleep      = sleep_q;

   AST_CAL_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == ST_CAL) |-> !data_rdy); // R1

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      burst_start |=> !burst_start); // R4

   AST_START_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      burst_start |-> !data_rdy); // R4

   AST_DONE_RELEASES_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == ST_BURST && burst_done) |=> (data_rdy && !asleep)); // R4

   AST_SLEEP_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !data_rdy); // R5

   AST_SLEEP_NEEDS_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep) |-> $past(!sel_hi)); // R5

   AST_SCLK_WAKE_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == ST_SLEEP && sclk_rise && !sel_rise) |=> (!burst_start && !asleep)); // R7

   AST_BURST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == ST_BURST && !burst_done) |=> !burst_start); // R9

endmodule

// File: tb/tb_acq_sleep_seq.sv
module tb_acq_sleep_seq;

   localparam int CAL    = 40;
   localparam int QUIET  = 30;
   localparam int SETTLE = 10;
   localparam int DUMMY  = 25;
   localparam int WAKE   = 200;
   localparam int FREE   = 120;
   localparam int BL     = 8;
   localparam int LAT    = 3;

   logic clk = 1'b0;
   logic rst_n, sel_n, sclk, burst_done;
   logic data_rdy, burst_start, asleep;

   int nchk = 0;
   int nfail = 0;
   int nstarts = 0;
   int dcnt = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   acq_sleep_seq #(
      .SYNC_STAGES      (2),
      .CAL_TICKS        (CAL),
      .QUIET_TICKS      (QUIET),
      .SETTLE_TICKS     (SETTLE),
      .DUMMY_HOLD_TICKS (DUMMY),
      .WAKE_TICKS       (WAKE),
      .FREE_RUN_TICKS   (FREE)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_n       (sel_n),
      .sclk        (sclk),
      .burst_done  (burst_done),
      .data_rdy    (data_rdy),
      .burst_start (burst_start),
      .asleep      (asleep)
   );

   // measurement engine model: done pulse BL cycles after each start
   initial begin
      burst_done = 1'b0;
      forever begin
         @(negedge clk);
         burst_done = 1'b0;
         if (dcnt > 0) begin
            dcnt = dcnt - 1;
            if (dcnt == 0) burst_done = 1'b1;
         end
         if (burst_start) begin
            nstarts = nstarts + 1;
            dcnt = BL;
         end
      end
   end

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_near(input string tag, input int act, input int exp, input int tol);
      check((act >= exp - tol) && (act <= exp + tol), tag, act, exp);
   endtask

   // which: 0 start pulse, 1 data_rdy high, 2 asleep high, 3 asleep low
   task automatic wait_sig(input int which, input int maxc, output int lat);
      lat = -1;
      for (int i = 1; i <= maxc; i++) begin
         @(negedge clk);
         if ((which == 0 && burst_start) || (which == 1 && data_rdy) ||
             (which == 2 && asleep) || (which == 3 && !asleep)) begin
            lat = i;
            break;
         end
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sclk_pulse();
      sclk = 1'b1;
      ticks(2);
      sclk = 1'b0;
      ticks(2);
   endtask

   task automatic wait_idle();
      int l;
      while (dcnt != 0 || burst_done) @(negedge clk);
      wait_sig(1, 50, l);
   endtask

   function automatic int exp_delay(input int pulses);
      return (pulses > 0) ? (SETTLE + LAT) : (DUMMY + LAT);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", 100000);
         report();
         $finish;
      end
   end

   initial begin
      int lat, base, npulse, off;
      void'($urandom(32'd7341));
      rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0;
      ticks(5);
      check(!data_rdy, "R1 reset data_rdy", data_rdy, 0);
      check(!burst_start, "R1 reset burst_start", burst_start, 0);
      check(!asleep, "R1 reset asleep", asleep, 0);
      rst_n = 1'b1;
      wait_sig(1, 200, lat);
      check_near("R1 calibration length", lat, CAL, 3);

      // free-running with select high
      wait_sig(0, 400, lat);
      check_near("R8 first free-run burst", lat, FREE, 3);
      check(!data_rdy, "R4 data_rdy low at start", data_rdy, 0);
      ticks(1);
      check(!burst_start, "R4 start is single cycle", burst_start, 0);
      wait_sig(1, 50, lat);
      check_near("R4 data_rdy back after done", lat, BL, 2);
      wait_sig(0, 400, lat);
      check_near("R8 period after done", lat, FREE, 3);
      wait_idle();

      // clocked frame
      sel_n = 1'b0; ticks(2);
      repeat (4) sclk_pulse();
      sel_n = 1'b1;
      ticks(6);
      check(data_rdy, "R2 data_rdy high while pending", data_rdy, 1);
      wait_sig(0, 100, lat);
      check_near("R2 settle delay", lat + 6, SETTLE + LAT, 3);
      wait_idle();

      // short dummy pulse
      base = nstarts;
      sel_n = 1'b0; ticks(10); sel_n = 1'b1;
      wait_sig(0, 100, lat);
      check_near("R3 dummy hold delay", lat, DUMMY + LAT, 3);
      ticks(50);
      check(nstarts - base == 1, "R3 one burst per dummy pulse", nstarts - base, 1);
      wait_idle();

      // activity during pending and burst
      sel_n = 1'b0; ticks(5); sel_n = 1'b1;
      ticks(8);
      sel_n = 1'b0; ticks(3); sel_n = 1'b1;
      wait_sig(0, 100, lat);
      check_near("R9 pending delay not shifted", lat + 11, DUMMY + LAT, 3);
      base = nstarts;
      sel_n = 1'b0; sclk_pulse(); sel_n = 1'b1;
      ticks(60);
      check(nstarts == base, "R9 no extra burst", nstarts - base, 0);
      wait_idle();

      // quiet time and sleep
      sel_n = 1'b0; ticks(2);
      sclk_pulse(); ticks(10); sclk_pulse(); ticks(20); sclk_pulse();
      check(!asleep, "R10 clocks keep block awake", asleep, 0);
      wait_sig(2, 200, lat);
      check_near("R10 quiet from last clock", lat + 4, QUIET + LAT, 3);
      check(!data_rdy, "R5 data_rdy low asleep", data_rdy, 0);

      // clock wakes without burst
      base = nstarts;
      sclk = 1'b1;
      wait_sig(3, 20, lat);
      check_near("R7 wake on clock", lat, LAT, 2);
      ticks(1);
      check(data_rdy, "R7 data_rdy after wake", data_rdy, 1);
      sclk = 1'b0;
      wait_sig(2, 200, lat);
      check(lat > 0, "R5 sleeps again", lat, QUIET);
      check(nstarts == base, "R7 no burst from clock", nstarts - base, 0);

      // periodic wake
      wait_sig(0, WAKE + SETTLE + 50, lat);
      check_near("R6 periodic wake burst", lat, WAKE + SETTLE, 4);
      check(!asleep, "R6 awake during burst", asleep, 0);
      wait_idle();
      wait_sig(2, 200, lat);
      check_near("R6 back to sleep", lat, QUIET, 4);

      // long dummy pulse from sleep
      sel_n = 1'b1;
      wait_sig(0, 100, lat);
      wait_idle();
      sel_n = 1'b0;
      wait_sig(2, 200, lat);
      ticks(20);
      sel_n = 1'b1;
      wait_sig(0, 100, lat);
      check_near("R3 dummy rise from sleep", lat, DUMMY + LAT, 3);
      wait_idle();

      // select rise around quiet expiry
      for (int it = 0; it < 12; it++) begin
         npulse = int'($urandom_range(0, 2));
         off = int'($urandom_range(0, 8)) - 4;
         base = nstarts;
         sel_n = 1'b0; ticks(2);
         for (int p = 0; p < npulse; p++) sclk_pulse();
         ticks(QUIET + off);
         sel_n = 1'b1;
         wait_sig(0, 100, lat);
         check_near("R11 delay at quiet expiry", lat, exp_delay(npulse), 3);
         ticks(30);
         check(nstarts - base == 1, "R11 single burst at quiet expiry", nstarts - base, 1);
         wait_idle();
      end

      finished = 1'b1;
      report();
      $finish;
   end

endmodule